// File: doc/BRIEF.md
# Six-Channel Gate Enable Selector

This block produces six registered gate-enable levels for a bank of low-side switches. In normal operation each channel is switched on by its bit in a six-bit command register, which the serial front end loads with a one-cycle write strobe. Two parallel logic pins are ORed onto channels 2 and 3. A mode pin switches the block into a direct pulse-width mode. In that mode two pulse pins drive the outer channel pairs, the parallel pins keep channels 2 and 3, and the serial path is locked out.

Two clean supply flags, one for over-voltage and one for low logic supply, turn every gate off in either mode. The mode pin, the supply flags, the parallel pins and the pulse pins are all asynchronous. Each passes through a parameterised flop synchronizer before it reaches the gate register. The command word and its strobe are already in the system clock domain.

Top module: `hsgate_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, `gate_en` becomes 000000, `ser_lock` becomes 0 and the command register is cleared, so gates stay off after reset until a new write.
- R2: In normal mode (`ovr_mode` low), `gate_en[N]` (bit N = channel N) is 1 when command bit N is 1. A word presented with `cmd_wr` high on one edge reaches `gate_en` on the following edge, two edges in all.
- R3: In normal mode, `par_in[0]` is ORed into channel 2 and `par_in[1]` into channel 3. Channels 0, 1, 4 and 5 follow their command bit alone.
- R4: In override mode, channels 0 and 1 both equal `pw_a`, and channels 4 and 5 both equal `pw_b`. The command register has no effect on these channels.
- R5: In override mode, channel 2 equals `par_in[0]` and channel 3 equals `par_in[1]`. Command bits 2 and 3 have no effect.
- R6: While override is active, `cmd_wr` is ignored and the command register keeps its value. After override is released, the gates again show the word written before override.
- R7: `ser_lock` is 1 exactly while the synchronised override mode is active.
- R8: `ov_flag` high forces all six gates off in either mode.
- R9: `uv_flag` high forces all six gates off in either mode.
- R10: A change on any asynchronous pin reaches `gate_en` or `ser_lock` after exactly SYNC_STAGES+1 rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_word | input | 6 | Command word from the serial front end, bit N = channel N |
| cmd_wr | input | 1 | One-cycle strobe that loads `cmd_word` |
| par_in | input | 2 | Asynchronous parallel inputs for channels 2 and 3 |
| pw_a | input | 1 | Asynchronous direct pulse input for channels 0 and 1 |
| pw_b | input | 1 | Asynchronous direct pulse input for channels 4 and 5 |
| ovr_mode | input | 1 | Asynchronous override mode pin |
| ov_flag | input | 1 | Supply over-voltage flag |
| uv_flag | input | 1 | Low logic-supply flag |
| gate_en | output | 6 | Registered gate enables, bit N = channel N |
| ser_lock | output | 1 | High while the serial path is locked out |

## Verification
The bench builds the block with SYNC_STAGES = 3, one stage deeper than the default. This checks that the synchronizer chain and the R10 latency come from the parameter rather than being fixed at two. It also means the lockout window opens and closes one cycle later than the default would give. With that depth, the bench can show that a write strobe arriving just after the mode pin rises is still taken while the synchronised lock is low. A strobe that arrives after the lock has propagated is dropped.

// File: rtl/hsg_pkg.sv
package hsg_pkg;
  localparam int CH_NUM  = 6;
  localparam int PAR_NUM = 2;

  typedef logic [CH_NUM-1:0]  gate_vec_t;
  typedef logic [PAR_NUM-1:0] par_vec_t;

  // Bundle of the asynchronous control pins after synchronisation
  typedef struct packed {
    logic     ovr;
    logic     ov;
    logic     uv;
    logic     pwa;
    logic     pwb;
    par_vec_t par;
  } pin_bus_t;

  localparam int PIN_W = $bits(pin_bus_t);

  typedef enum logic {
    MODE_NORMAL   = 1'b0,
    MODE_OVERRIDE = 1'b1
  } gate_mode_e;
endpackage

// File: rtl/hsg_sync.sv
module hsg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[LAST];
endmodule

// File: rtl/hsg_cmd_store.sv
module hsg_cmd_store
  import hsg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lock,
  input  logic      wr,
  input  gate_vec_t wdata,
  output gate_vec_t q
);
  always_ff @(posedge clk) begin
    if (rst)             q <= '0;
    else if (wr && !lock) q <= wdata;
  end

  AST_LOCK_HOLDS_CMD: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(q)); // R6

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (q == '0)); // R1
endmodule

// File: rtl/hsg_gate_select.sv
module hsg_gate_select
  import hsg_pkg::*;
#(
  parameter int PAR_CH_LO = 2,
  parameter int PAR_CH_HI = 3
) (
  input  gate_mode_e mode,
  input  gate_vec_t  cmd,
  input  par_vec_t   par,
  input  logic       pwa,
  input  logic       pwb,
  output gate_vec_t  sel
);
  localparam int HALF = CH_NUM / 2;

  always_comb begin
    sel = '0;
    for (int n = 0; n < CH_NUM; n++) begin
      if (mode == MODE_NORMAL) begin
        sel[n] = cmd[n];
        if (n == PAR_CH_LO) sel[n] = cmd[n] | par[0];
        if (n == PAR_CH_HI) sel[n] = cmd[n] | par[1];
      end else begin
        if (n == PAR_CH_LO)      sel[n] = par[0];
        else if (n == PAR_CH_HI) sel[n] = par[1];
        else if (n < HALF)       sel[n] = pwa;
        else                     sel[n] = pwb;
      end
    end
  end
endmodule

// File: rtl/hsg_ctrl.sv
module hsgate_ctrl
  import hsg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] cmd_word,
  input  logic       cmd_wr,
  input  logic [1:0] par_in,
  input  logic       pw_a,
  input  logic       pw_b,
  input  logic       ovr_mode,
  input  logic       ov_flag,
  input  logic       uv_flag,
  output logic [5:0] gate_en,
  output logic       ser_lock
);
  pin_bus_t   pins_raw, pins_s;
  gate_vec_t  cmd_q, sel;
  gate_mode_e mode;
  logic       kill;

  assign pins_raw = '{ovr: ovr_mode, ov: ov_flag, uv: uv_flag,
                      pwa: pw_a, pwb: pw_b, par: par_in};

  hsg_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pins_raw),
    .dout (pins_s)
  );

  assign mode = pins_s.ovr ? MODE_OVERRIDE : MODE_NORMAL;
  assign kill = pins_s.ov | pins_s.uv;

  hsg_cmd_store u_cmd (
    .clk   (clk),
    .rst   (rst),
    .lock  (pins_s.ovr),
    .wr    (cmd_wr),
    .wdata (cmd_word),
    .q     (cmd_q)
  );

  hsg_gate_select #(.PAR_CH_LO(2), .PAR_CH_HI(3)) u_sel (
    .mode (mode),
    .cmd  (cmd_q),
    .par  (pins_s.par),
    .pwa  (pins_s.pwa),
    .pwb  (pins_s.pwb),
    .sel  (sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_en  <= '0;
      ser_lock <= 1'b0;
    end else begin
      gate_en  <= kill ? '0 : sel;
      ser_lock <= pins_s.ovr;
    end
  end

  AST_OV_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    pins_s.ov |=> (gate_en == '0)); // R8

  AST_UV_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    pins_s.uv |=> (gate_en == '0)); // R9

  AST_PAIRS_TRACK: assert property (@(posedge clk) disable iff (rst)
    (pins_s.ovr && !kill) |=> (gate_en[0] == gate_en[1]) && (gate_en[4] == gate_en[5])); // R4

  AST_LOCK_FLAG: assert property (@(posedge clk) disable iff (rst)
    pins_s.ovr |=> ser_lock); // R7

  AST_RESET_OFF: assert property (@(posedge clk)
    rst |=> (gate_en == '0) && !ser_lock); // R1
endmodule

// File: tb/sim_hsgate_ctrl.sv
module sim_hsgate_ctrl;
  localparam int SYNC = 3;
  localparam int LAT  = SYNC + 1;
  localparam int NV   = 12;

  // {cmd[5:0], par[1:0], pwa, pwb, ovr, ov, uv, expected[5:0]}
  localparam logic [18:0] VEC [NV] = '{
    {6'b000000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000000}, // R2
    {6'b101010, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b101010}, // R2
    {6'b000000, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000100}, // R3
    {6'b000000, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b001000}, // R3
    {6'b000001, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'b001101}, // R3
    {6'b111111, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000000}, // R4
    {6'b000000, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000011}, // R4
    {6'b000000, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 6'b110000}, // R4
    {6'b111111, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000100}, // R5
    {6'b000000, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 6'b111011}, // R5
    {6'b111111, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'b000000}, // R8
    {6'b000000, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 6'b000000}  // R9
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] cmd_word = '0;
  logic       cmd_wr = 1'b0;
  logic [1:0] par_in = '0;
  logic       pw_a = 1'b0, pw_b = 1'b0, ovr_mode = 1'b0;
  logic       ov_flag = 1'b0, uv_flag = 1'b0;
  logic [5:0] gate_en;
  logic       ser_lock;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  hsgate_ctrl #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst(rst), .cmd_word(cmd_word), .cmd_wr(cmd_wr),
    .par_in(par_in), .pw_a(pw_a), .pw_b(pw_b), .ovr_mode(ovr_mode),
    .ov_flag(ov_flag), .uv_flag(uv_flag), .gate_en(gate_en), .ser_lock(ser_lock)
  );

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [5:0] w);
    cmd_word = w;
    cmd_wr   = 1'b1;
    cyc(1);
    cmd_wr   = 1'b0;
  endtask

  task automatic quiet();
    ovr_mode = 0; ov_flag = 0; uv_flag = 0; par_in = 0; pw_a = 0; pw_b = 0;
    cyc(LAT + 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    cyc(3);
    chk("R1 reset gates", {ser_lock, gate_en}, 7'b0);
    rst = 1'b0;
    cyc(LAT + 2);
    chk("R1 after reset", {ser_lock, gate_en}, 7'b0);

    for (int v = 0; v < NV; v++) begin
      quiet();
      write_cmd(VEC[v][18:13]);
      par_in   = VEC[v][12:11];
      pw_a     = VEC[v][10];
      pw_b     = VEC[v][9];
      ovr_mode = VEC[v][8];
      ov_flag  = VEC[v][7];
      uv_flag  = VEC[v][6];
      cyc(LAT + 1);
      chk($sformatf("R2-vector %0d", v), {1'b0, gate_en}, {1'b0, VEC[v][5:0]});
    end

    // R2 latency: command reaches gates on the second edge
    quiet();
    write_cmd(6'b000000);
    cyc(2);
    cmd_word = 6'b010010; cmd_wr = 1'b1;
    cyc(1);
    cmd_wr = 1'b0;
    chk("R2 not yet after one edge", {1'b0, gate_en}, 7'b0);
    cyc(1);
    chk("R2 after two edges", {1'b0, gate_en}, 7'b0010010);

    // R6: write during lockout ignored, old word restored
    quiet();
    write_cmd(6'b000011);
    ovr_mode = 1'b1;
    cyc(LAT + 1);
    chk("R7 lock high", {ser_lock, 6'b0}, 7'b1000000);
    write_cmd(6'b111100);
    ovr_mode = 1'b0;
    cyc(LAT + 1);
    chk("R6 locked write dropped", {ser_lock, gate_en}, 7'b0000011);

    // R10: latency of an async pin is SYNC+1 edges
    quiet();
    ovr_mode = 1'b1;
    cyc(LAT + 1);
    pw_b = 1'b1;
    cyc(LAT - 1);
    chk("R10 before latency", {1'b0, gate_en}, 7'b0);
    cyc(1);
    chk("R10 at latency", {1'b0, gate_en}, 7'b0110000);

    // R1: reset mid-run clears gates and command register
    quiet();
    write_cmd(6'b100001);
    cyc(2);
    rst = 1'b1;
    cyc(1);
    chk("R1 reset mid-run", {ser_lock, gate_en}, 7'b0);
    rst = 1'b0;
    cyc(LAT + 2);
    chk("R1 cmd cleared", {ser_lock, gate_en}, 7'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule